// File: doc/BRIEF.md
# Register Stack Save/Restore Sequencer

This block moves general-purpose register values to and from a stack in memory that grows toward lower addresses. It keeps the stack pointer itself, reads and writes an external eight-entry register file through one read port and one write port, and issues one memory transfer at a time over a request/acknowledge handshake.

A command picks one of four operations:
- a single push of one register,
- a single pop into one register,
- a bulk save of all eight registers,
- a bulk restore of all eight registers.

A size input selects full-width slots (DW/8 bytes, 4 bytes at the default width) or 16-bit slots (2 bytes). A long-mode input forbids the two bulk operations. In long mode, a bulk request is refused with a one-cycle illegal pulse. A done pulse closes every accepted command.

Register file indices used by the bulk operations are fixed:

| Index | Register |
|-------|----------|
| 0 | A |
| 1 | C |
| 2 | D |
| 3 | B |
| 4 | stack-pointer slot |
| 5 | BP |
| 6 | SI |
| 7 | DI |

The bulk save walks these indices upward. It stores the pointer value captured at command start in place of entry 4. The bulk restore walks the indices downward and skips the pointer slot. The pointer ends up correct because of the pops themselves.

Top module: `stack_seq`

## Requirements
- R1: A push (cmd_op 0) issues one write at sp minus the slot size (4 bytes when cmd_wide=1, 2 bytes when 0). It stores the register file entry cmd_reg there and leaves sp at that lower address. In 16-bit mode only bits 15:0 are stored, mem_wdata upper bits are zero, and mem_wide is 0.
- R2: A pop (cmd_op 1) issues one read at sp, writes the data to entry cmd_reg, and raises sp by the slot size. In 16-bit mode only bits 15:0 of the entry change; its upper bits keep their old value.
- R3: A bulk save (cmd_op 2) writes register file entries 0 through 7 in that order. Slot k lands at old_sp-(k+1)*size. Slot 4 holds the stack pointer value from before the command, not register file entry 4.
- R4: A bulk restore (cmd_op 3) reads slot k at old_sp+k*size into entry 7-k. The slot for k=3 (entry 4) is read but discarded, and entry 4 is never written.
- R5: A bulk operation changes sp by eight slots in total: 32 bytes in full-width mode, 16 bytes in 16-bit mode. The change is downward for a save and upward for a restore.
- R6: With long_mode=1, a bulk request produces a single-cycle illegal pulse in the cycle after it is presented. It makes no memory transfer and changes neither sp nor any register. Single push and pop still work in long mode.
- R7: Each acknowledged transfer counts once: a single operation makes exactly one transfer and a bulk operation exactly eight. While mem_req waits for mem_ack, mem_addr, mem_we and mem_wdata stay unchanged.
- R8: done is high for exactly one cycle, the cycle right after the final transfer is acknowledged.
- R9: A cmd_valid presented while busy is high is ignored, with no effect on transfers, sp or registers.
- R10: After reset, sp equals SP_INIT and busy, done, illegal and mem_req are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 bulk save, 3 bulk restore |
| cmd_reg | input | 3 | Register file index for push and pop |
| cmd_wide | input | 1 | 1 selects full-width slots, 0 selects 16-bit slots |
| long_mode | input | 1 | 1 forbids bulk operations |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a refused bulk request |
| sp | output | AW | Current stack pointer |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | DW | Register file write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Transfer size: 1 full width, 0 16-bit |
| mem_addr | output | AW | Byte address of the transfer |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
The bench builds the block with DW=32, AW=12 and SP_INIT=0x800. A 12-bit byte address lets a 4096-byte array in the bench mirror the whole address space, so every slot the block touches can be checked, including slots reached after long random runs of pushes, pops and bulk operations in both slot sizes. Acknowledge latency is randomised, which exercises the hold rule for a waiting request and the done timing against the true final acknowledge.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [2:0]    cmd_reg,
  input  logic          cmd_wide,
  input  logic          long_mode,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] sp,
  output logic [2:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [2:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam logic [1:0] OP_PUSH = 2'd0;
  localparam logic [1:0] OP_SAVE = 2'd2;
  localparam logic [1:0] OP_REST = 2'd3;
  localparam logic [2:0] SP_SLOT = 3'd4;
  localparam logic [AW-1:0] WIDE_STEP = AW'(DW / 8);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [2:0]    reg_q;
  logic [2:0]    cnt;
  logic          wide_q;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_lat;
  logic          ill_q;

  wire            accept  = (st == S_IDLE) && cmd_valid && !(cmd_op[1] && long_mode);
  wire            refuse  = (st == S_IDLE) && cmd_valid && cmd_op[1] && long_mode;
  wire            is_push = !op_q[0];
  wire            last    = !op_q[1] || (cnt == 3'd7);
  wire            fire    = (st == S_XFER) && mem_ack;
  wire [AW-1:0]   step    = wide_q ? WIDE_STEP : HALF_STEP;
  wire [2:0]      slot    = op_q[1] ? (op_q[0] ? ~cnt : cnt) : reg_q;
  wire            sp_src  = (op_q == OP_SAVE) && (cnt == SP_SLOT);
  wire            drop    = (op_q == OP_REST) && (cnt == 3'd3);
  wire [DW-1:0]   src     = sp_src ? DW'(sp_lat) : rf_rdata;

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign illegal   = ill_q;
  assign sp        = sp_q;
  assign rf_raddr  = slot;
  assign rf_waddr  = slot;
  assign rf_we     = fire && !is_push && !drop;
  assign rf_wdata  = wide_q ? mem_rdata : {rf_rdata[DW-1:16], mem_rdata[15:0]};
  assign mem_req   = (st == S_XFER);
  assign mem_we    = is_push;
  assign mem_wide  = wide_q;
  assign mem_addr  = is_push ? sp_q - step : sp_q;
  assign mem_wdata = wide_q ? src : {{(DW-16){1'b0}}, src[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_PUSH;
      reg_q  <= '0;
      cnt    <= '0;
      wide_q <= 1'b1;
      sp_q   <= SP_INIT;
      sp_lat <= SP_INIT;
      ill_q  <= 1'b0;
    end else begin
      ill_q <= refuse;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_XFER;
          op_q   <= cmd_op;
          reg_q  <= cmd_reg;
          wide_q <= cmd_wide;
          sp_lat <= sp_q;
          cnt    <= '0;
        end
        S_XFER: if (mem_ack) begin
          sp_q <= is_push ? sp_q - step : sp_q + step;
          cnt  <= cnt + 3'd1;
          if (last) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_push_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_push) |=> (sp_q == $past(mem_addr)));

  assert_pop_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_push) |=> (sp_q == $past(mem_addr) + $past(step)));

  assert_skip_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && op_q == OP_REST) |-> (rf_waddr != SP_SLOT));

  assert_bulk_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1]) |-> (sp_q == (op_q[0] ? sp_lat + (step << 3) : sp_lat - (step << 3))));

  assert_refuse_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !rf_we && !busy));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(op_q) && $stable(reg_q) && $stable(wide_q)));

endmodule

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [2:0] cmd_reg = 0;
  logic cmd_wide = 1;
  logic long_mode = 0;
  logic busy, done, illegal;
  logic [AW-1:0] sp;
  logic [2:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata;
  logic rf_we;
  logic mem_req, mem_we, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = 0;
  logic mem_ack = 0;

  logic [31:0] regs [8];
  logic [7:0]  bmem [4096];
  int checks = 0, fails = 0, cyc = 0, last_ack = -1, nxfer = 0;
  logic [AW-1:0] exp_sp;

  always #5 clk = ~clk;

  stack_seq #(.DW(DW), .AW(AW), .SP_INIT(12'h800)) u_stack_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_wide(cmd_wide), .long_mode(long_mode),
    .busy(busy), .done(done), .illegal(illegal), .sp(sp),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_ack) begin
      last_ack = cyc;
      nxfer++;
    end
    if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  function automatic logic [31:0] rd(input logic [AW-1:0] a, input bit w);
    logic [AW-1:0] a1 = a + 12'd1, a2 = a + 12'd2, a3 = a + 12'd3;
    if (w) return {bmem[a3], bmem[a2], bmem[a1], bmem[a]};
    return {16'h0, bmem[a1], bmem[a]};
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input bit w);
    return w ? v : {16'h0, v[15:0]};
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && ($urandom % 3 == 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata[7:0];
        bmem[mem_addr + 12'd1] = mem_wdata[15:8];
        if (mem_wide) begin
          bmem[mem_addr + 12'd2] = mem_wdata[23:16];
          bmem[mem_addr + 12'd3] = mem_wdata[31:24];
        end
      end else mem_rdata <= rd(mem_addr, mem_wide);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int r, input bit w, input bit lm, input bit poke);
    logic [31:0] pre [8];
    logic [AW-1:0] s0 = exp_sp;
    logic [AW-1:0] sz = w ? 12'd4 : 12'd2;
    int x0 = nxfer, nd = 0, ni = 0, t = 0;
    bit late = 0, bulk = (op >= 2);
    for (int k = 0; k < 8; k++) pre[k] = regs[k];
    @(negedge clk);
    cmd_valid = 1; cmd_op = op[1:0]; cmd_reg = r[2:0]; cmd_wide = w; long_mode = lm;
    @(negedge clk);
    cmd_valid = 0;
    while (t < 400) begin
      if (done) begin nd++; if (cyc != last_ack) late = 1; end
      if (illegal) ni++;
      if (poke && t == 3) begin cmd_valid = 1; cmd_op = 2'd0; cmd_reg = 3'd1; end
      else if (poke && t == 4) cmd_valid = 0;
      if (!busy && !done && !illegal && (nd + ni) > 0) break;
      @(negedge clk);
      t++;
    end
    long_mode = 0;
    chk(t < 400, "R8 completion", t, 400);
    if (bulk && lm) begin
      chk(ni == 1 && nd == 0, "R6 illegal pulse", ni, 1);
      chk(nxfer == x0, "R6 no transfer", nxfer - x0, 0);
      chk(sp == s0, "R6 sp unchanged", sp, s0);
      for (int k = 0; k < 8; k++) chk(regs[k] == pre[k], "R6 regs unchanged", regs[k], pre[k]);
      return;
    end
    chk(nd == 1 && !late && ni == 0, "R8 done pulse", nd, 1);
    chk(nxfer - x0 == (bulk ? 8 : 1), poke ? "R9 ignored while busy" : "R7 transfer count", nxfer - x0, bulk ? 8 : 1);
    case (op)
      0: begin
        exp_sp = s0 - sz;
        chk(rd(exp_sp, w) == msk(pre[r], w), "R1 pushed value", rd(exp_sp, w), msk(pre[r], w));
      end
      1: begin
        logic [31:0] e = w ? rd(s0, 1) : {pre[r][31:16], rd(s0, 0)[15:0]};
        exp_sp = s0 + sz;
        chk(regs[r] == e, "R2 popped value", regs[r], e);
      end
      2: begin
        exp_sp = s0 - (sz << 3);
        for (int k = 0; k < 8; k++) begin
          logic [31:0] e = msk((k == 4) ? 32'(s0) : pre[k], w);
          logic [AW-1:0] a = s0 - sz * 12'(k + 1);
          chk(rd(a, w) == e, "R3 save slot", rd(a, w), e);
        end
      end
      default: begin
        exp_sp = s0 + (sz << 3);
        for (int k = 0; k < 8; k++) begin
          logic [AW-1:0] a = s0 + sz * 12'(k);
          logic [31:0] e = (k == 3) ? pre[4] :
                           (w ? rd(a, 1) : {pre[7-k][31:16], rd(a, 0)[15:0]});
          chk(regs[7-k] == e, "R4 restore slot", regs[7-k], e);
        end
      end
    endcase
    chk(sp == exp_sp, bulk ? "R5 bulk sp" : "R1/R2 sp", sp, exp_sp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) regs[k] = $urandom;
    for (int k = 0; k < 4096; k++) bmem[k] = 8'($urandom);
    exp_sp = 12'h800;
    repeat (3) @(negedge clk);
    chk(sp == 12'h800, "R10 reset sp", sp, 12'h800);
    chk(!busy && !done && !illegal && !mem_req, "R10 reset outputs",
        {busy, done, illegal, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    do_op(0, 2, 1, 0, 0);
    do_op(1, 5, 0, 0, 0);
    do_op(0, 6, 0, 0, 0);
    do_op(1, 3, 1, 0, 0);
    do_op(2, 0, 1, 0, 0);
    do_op(3, 0, 1, 0, 0);
    do_op(2, 0, 0, 0, 0);
    do_op(3, 0, 0, 0, 0);
    do_op(2, 0, 1, 1, 0);
    do_op(3, 0, 0, 1, 0);
    do_op(0, 7, 1, 1, 0);
    do_op(1, 1, 1, 1, 0);
    do_op(2, 0, 1, 0, 1);
    do_op(3, 0, 1, 0, 1);
    for (int i = 0; i < 80; i++) begin
      int op = $urandom % 4;
      if (exp_sp < 12'h400) op = op | 1;
      if (exp_sp > 12'hC00) op = op & 2;
      do_op(op, $urandom % 8, $urandom % 2, ($urandom % 5) == 0, ($urandom % 4) == 0 && op >= 2);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule